// File: doc/BRIEF.md
# Overlay Window Scanout Address Generator

This block serves one overlay window of a display pipeline. From a buffer base address, a row pitch, a pixel format, a source crop offset, a window size and an on-screen position it works out where the window's pixels sit in memory. These are the first byte, the byte just past the region, the bytes fetched per line and the bytes skipped between lines. It also gives the bottom-right corner of the window on screen.

During scanout the block walks a fetch address through the region one line at a time. It issues burst requests, each an address and a beat count in 32-bit words, on a valid/ready request interface. The burst size depends on the pixel format and on how wide the buffer is.

Configuration inputs are sampled only on the frame-boundary strobe. That strobe also restarts the walk at the start of the region. Between strobes, software may change the configuration inputs freely.

Top module: `ovl_scan_addr_gen`

## Requirements
- R1: On the cycle after `vsync` is high, `start_addr` equals base + src_x * bpp + src_y * pitch. The format codes map to bytes per pixel as follows: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R2: On the cycle after `vsync`, `end_addr` equals `start_addr` + pitch * win_h.
- R3: On the cycle after `vsync`, `line_len` equals win_w * bpp and `line_skip` equals pitch - `line_len`.
- R4: Nominal burst length is 8 words for format 0 and 16 words for formats 1, 2 and 3.
- R5: When `cfg_fb_width` is below 128, every burst is at most 4 words, whatever the format.
- R6: On the cycle after `vsync`, `br_x` equals pos_x + win_w and `br_y` equals pos_y + win_h.
- R7: Within a line, bursts start at the line's first byte and follow one another with no gap. Each burst carries the nominal length, except the last, which carries only the words that remain (ceil(remaining bytes / 4)). The next line starts one pitch after the previous line's start, which is `line_len` + `line_skip` further on.
- R8: After win_h lines have been accepted, `req_valid` stays low until the next `vsync`. A window with zero width or zero height issues no request.
- R9: Changes on the configuration inputs while `vsync` is low have no effect on any output.
- R10: `vsync` reloads the fetch address to the new `start_addr`. This holds even mid-frame, and a burst handshake in the same cycle is discarded.
- R11: While `req_valid` is high and `req_ready` is low, `req_addr` and `req_beats` hold.
- R12: After reset, `req_valid` is low and all address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Frame-boundary strobe; samples configuration and restarts scanout |
| cfg_base | input | AW | Buffer base byte address |
| cfg_pitch | input | PW | Bytes per buffer row |
| cfg_fmt | input | 2 | Pixel format code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| cfg_src_x | input | CW | Source crop x offset in pixels |
| cfg_src_y | input | CW | Source crop y offset in rows |
| cfg_win_w | input | CW | Window width in pixels |
| cfg_win_h | input | CW | Window height in rows |
| cfg_pos_x | input | CW | On-screen left edge |
| cfg_pos_y | input | CW | On-screen top edge |
| cfg_fb_width | input | CW | Buffer width in pixels |
| req_ready | input | 1 | Memory side accepts the current burst |
| req_valid | output | 1 | Burst request pending |
| req_addr | output | AW | Burst byte address |
| req_beats | output | BW | Burst length in 32-bit words |
| start_addr | output | AW | First byte of the region |
| end_addr | output | AW | Byte past the region |
| line_len | output | PW | Bytes fetched per line |
| line_skip | output | PW | Bytes skipped after each line |
| br_x | output | CW+1 | On-screen right edge |
| br_y | output | CW+1 | On-screen bottom edge |

## Verification
A frame strobe and the acceptance of a burst can fall in the same cycle. In that case the reload has to win, and the half-finished walk must leave no trace. The bench provokes this by raising `vsync` together with a new configuration while a burst is valid and `req_ready` is high. It then requires the very next request to carry the new start address and the new first-burst length. It also follows the rest of the new frame against its own model.

// File: rtl/ovl_scan_addr_gen.sv
module ovl_scan_addr_gen #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int CW = 12,
  parameter int BW = 5,
  parameter int MIN_WIDE_PX = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic [AW-1:0] cfg_base,
  input  logic [PW-1:0] cfg_pitch,
  input  logic [1:0]    cfg_fmt,
  input  logic [CW-1:0] cfg_src_x,
  input  logic [CW-1:0] cfg_src_y,
  input  logic [CW-1:0] cfg_win_w,
  input  logic [CW-1:0] cfg_win_h,
  input  logic [CW-1:0] cfg_pos_x,
  input  logic [CW-1:0] cfg_pos_y,
  input  logic [CW-1:0] cfg_fb_width,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_beats,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] end_addr,
  output logic [PW-1:0] line_len,
  output logic [PW-1:0] line_skip,
  output logic [CW:0]   br_x,
  output logic [CW:0]   br_y
);
  localparam logic [BW-1:0] BL_NARROW = BW'(4);
  localparam logic [BW-1:0] BL_BYTE   = BW'(8);
  localparam logic [BW-1:0] BL_WIDE   = BW'(16);

  logic [2:0] bpp;
  always_comb begin
    case (cfg_fmt)
      2'd0:    bpp = 3'd1;
      2'd1:    bpp = 3'd2;
      default: bpp = 3'd4;
    endcase
  end

  wire [AW-1:0] n_start = cfg_base + AW'(cfg_src_x) * AW'(bpp) + AW'(cfg_src_y) * AW'(cfg_pitch);
  wire [AW-1:0] n_end   = n_start + AW'(cfg_pitch) * AW'(cfg_win_h);
  wire [PW-1:0] n_len   = PW'(cfg_win_w) * PW'(bpp);
  wire [BW-1:0] n_bl    = (cfg_fb_width < CW'(MIN_WIDE_PX)) ? BL_NARROW :
                          (cfg_fmt == 2'd0) ? BL_BYTE : BL_WIDE;

  logic [PW-1:0] r_pitch, offs;
  logic [BW-1:0] r_bl;
  logic [AW-1:0] line_a;
  logic          active;

  wire [PW-1:0] rem     = line_len - offs;
  wire [PW:0]   rem_up  = {1'b0, rem} + (PW+1)'(3);
  wire [PW-2:0] rem_w   = rem_up[PW:2];
  wire          last    = rem_w <= (PW-1)'(r_bl);
  wire [AW-1:0] next_ln = line_a + AW'(r_pitch);

  assign req_valid = active;
  assign req_addr  = line_a + AW'(offs);
  assign req_beats = last ? BW'(rem_w) : r_bl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      end_addr   <= '0;
      line_len   <= '0;
      line_skip  <= '0;
      br_x       <= '0;
      br_y       <= '0;
      r_pitch    <= '0;
      r_bl       <= '0;
      line_a     <= '0;
      offs       <= '0;
      active     <= 1'b0;
    end else if (vsync) begin
      start_addr <= n_start;
      end_addr   <= n_end;
      line_len   <= n_len;
      line_skip  <= cfg_pitch - n_len;
      br_x       <= {1'b0, cfg_pos_x} + {1'b0, cfg_win_w};
      br_y       <= {1'b0, cfg_pos_y} + {1'b0, cfg_win_h};
      r_pitch    <= cfg_pitch;
      r_bl       <= n_bl;
      line_a     <= n_start;
      offs       <= '0;
      active     <= (n_len != '0) && (cfg_win_h != '0);
    end else if (active && req_ready) begin
      if (last) begin
        offs   <= '0;
        line_a <= next_ln;
        if (next_ln >= end_addr) active <= 1'b0;
      end else begin
        offs <= offs + PW'({req_beats, 2'b00});
      end
    end
  end
endmodule

module ovl_scan_addr_gen_chk #(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int CW = 12,
  parameter int BW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic [CW-1:0] cfg_win_w,
  input logic [CW-1:0] cfg_win_h,
  input logic          req_ready,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [BW-1:0] req_beats,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] end_addr,
  input logic [PW-1:0] line_len
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !vsync) |=> ($stable(req_addr) && $stable(req_beats)));

  assert_beats_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0 && req_beats <= BW'(16)));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> ($stable(start_addr) && $stable(end_addr) && $stable(line_len)));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && cfg_win_w != '0 && cfg_win_h != '0) |=> (req_valid && req_addr == start_addr));

  assert_empty_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && (cfg_win_w == '0 || cfg_win_h == '0)) |=> !req_valid);
endmodule

bind ovl_scan_addr_gen ovl_scan_addr_gen_chk #(.AW(AW), .PW(PW), .CW(CW), .BW(BW)) u_chk (.*);

// File: tb/tb_ovl_scan_addr_gen.sv
module tb_ovl_scan_addr_gen;
  logic clk = 0, rst_n = 0, vsync = 0, req_ready = 0;
  logic [31:0] cfg_base = 0;
  logic [15:0] cfg_pitch = 0;
  logic [1:0]  cfg_fmt = 0;
  logic [11:0] cfg_src_x = 0, cfg_src_y = 0, cfg_win_w = 0, cfg_win_h = 0;
  logic [11:0] cfg_pos_x = 0, cfg_pos_y = 0, cfg_fb_width = 0;
  logic        req_valid;
  logic [31:0] req_addr, start_addr, end_addr;
  logic [4:0]  req_beats;
  logic [15:0] line_len, line_skip;
  logic [12:0] br_x, br_y;

  always #5 clk = ~clk;

  ovl_scan_addr_gen dut (.*);

  typedef struct packed {
    logic [31:0] base; logic [15:0] pitch; logic [1:0] fmt;
    logic [11:0] sx, sy, w, h, px, py, fbw;
    logic [31:0] e_start, e_end; logic [15:0] e_len, e_skip;
    logic [4:0] e_bl; logic [12:0] e_brx, e_bry;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h1000, 16'd64,  2'd2, 12'd2, 12'd1, 12'd5,   12'd3, 12'd10,  12'd20, 12'd16,
      32'h1048, 32'h1108, 16'd20,  16'd44,  5'd4,  13'd15,  13'd23},
    '{32'h2000, 16'd512, 2'd1, 12'd4, 12'd2, 12'd40,  12'd2, 12'd0,   12'd0,  12'd256,
      32'h2408, 32'h2808, 16'd80,  16'd432, 5'd16, 13'd40,  13'd2},
    '{32'h8000, 16'd256, 2'd0, 12'd3, 12'd0, 12'd10,  12'd2, 12'd100, 12'd50, 12'd200,
      32'h8003, 32'h8203, 16'd10,  16'd246, 5'd8,  13'd110, 13'd52},
    '{32'h4000, 16'd128, 2'd0, 12'd0, 12'd0, 12'd100, 12'd1, 12'd1,   12'd1,  12'd127,
      32'h4000, 32'h4080, 16'd100, 16'd28,  5'd4,  13'd101, 13'd2},
    '{32'h0,    16'd32,  2'd2, 12'd0, 12'd0, 12'd8,   12'd1, 12'd0,   12'd0,  12'd128,
      32'h0,    32'h20,   16'd32,  16'd0,   5'd16, 13'd8,   13'd1}
  };

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_base = v.base; cfg_pitch = v.pitch; cfg_fmt = v.fmt;
    cfg_src_x = v.sx; cfg_src_y = v.sy; cfg_win_w = v.w; cfg_win_h = v.h;
    cfg_pos_x = v.px; cfg_pos_y = v.py; cfg_fb_width = v.fbw;
  endtask

  task automatic pulse_vsync();
    vsync = 1;
    @(negedge clk);
    vsync = 0;
  endtask

  task automatic check_derived(input vec_t v);
    chk("R1 start_addr", start_addr, v.e_start);
    chk("R2 end_addr", end_addr, v.e_end);
    chk("R3 line_len", line_len, v.e_len);
    chk("R3 line_skip", line_skip, v.e_skip);
    chk("R6 br_x", br_x, v.e_brx);
    chk("R6 br_y", br_y, v.e_bry);
  endtask

  // Walks the expected bursts with req_ready high; starts at a negedge with the first burst shown.
  task automatic run_frame(input vec_t v, input int first_line, input int first_off);
    int off;
    int rem_w;
    int beats;
    off = first_off;
    for (int ln = first_line; ln < int'(v.h); ln++) begin
      while (off < int'(v.e_len)) begin
        rem_w = (int'(v.e_len) - off + 3) / 4;
        beats = (rem_w < int'(v.e_bl)) ? rem_w : int'(v.e_bl);
        chk("R7 req_valid", req_valid, 1);
        chk("R7 req_addr", req_addr, v.e_start + 32'(ln) * 32'(v.pitch) + 32'(off));
        chk((v.fbw < 128) ? "R5 req_beats" : "R4 req_beats", req_beats, beats);
        off += beats * 4;
        @(negedge clk);
      end
      off = 0;
    end
    chk("R8 idle after frame", req_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t z;
    @(negedge clk);
    chk("R12 reset req_valid", req_valid, 0);
    chk("R12 reset start_addr", start_addr, 0);
    chk("R12 reset end_addr", end_addr, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    req_ready = 1;
    foreach (VECS[i]) begin
      apply(VECS[i]);
      pulse_vsync();
      check_derived(VECS[i]);
      run_frame(VECS[i], 0, 0);
      repeat (2) @(negedge clk);
      chk("R8 stays idle", req_valid, 0);
    end

    // R9 and R11: load VECS[1], stall, then disturb the inputs without vsync
    req_ready = 0;
    apply(VECS[1]);
    pulse_vsync();
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R11 addr held", req_addr, VECS[1].e_start);
    chk("R11 beats held", req_beats, 16);
    chk("R9 start_addr unchanged", start_addr, VECS[1].e_start);
    chk("R9 line_len unchanged", line_len, VECS[1].e_len);
    req_ready = 1;
    run_frame(VECS[1], 0, 0);

    // R10: vsync together with an accepted burst mid-frame
    apply(VECS[0]);
    pulse_vsync();
    repeat (2) @(negedge clk);
    chk("R10 pre-reload busy", req_valid, 1);
    apply(VECS[2]);
    pulse_vsync();
    chk("R10 reload start_addr", start_addr, VECS[2].e_start);
    chk("R10 reload req_addr", req_addr, VECS[2].e_start);
    chk("R10 reload req_beats", req_beats, 3);
    run_frame(VECS[2], 0, 0);

    // R8: empty windows
    z = VECS[0]; z.w = 0;
    apply(z);
    pulse_vsync();
    chk("R8 zero width idle", req_valid, 0);
    z = VECS[0]; z.h = 0;
    apply(z);
    pulse_vsync();
    chk("R8 zero height idle", req_valid, 0);
    chk("R2 zero height end_addr", end_addr, VECS[0].e_start);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule